// File: doc/BRIEF.md
# Dual-Mode HDLC Frame Transmitter

This block turns bytes held in a small transmit FIFO into a one-bit serial stream for a 64 kbit/s bearer channel. A host writes bytes into the FIFO and steers the transmitter with three single-cycle commands: start (which also continues a frame when another block of bytes has been loaded), end, and transmitter reset. The serializer moves one line bit on each cycle where the bit-clock enable is high.

A mode input selects between two ways of sending. In framed mode the block wraps the payload as an HDLC frame: an opening flag, the payload with zero-bit stuffing, a 16-bit frame check sequence and a closing flag. If the FIFO runs dry mid-frame before an end command has arrived, the frame is aborted with a run of ones and a sticky underrun status is raised. In raw mode the FIFO bytes go out exactly as written, with no flags, no check sequence and no stuffing. Between frames, and after a reset, the line carries all ones. The host sees a ready output whenever the FIFO is empty.

Top module: `hdlc_dual_tx`

## Requirements
- R1: After rst_n is released, tx_bit is 1, fifo_ready is 1 and underrun is 0.
- R2: tx_bit changes only on the clock edge of a cycle where bit_en is high (or where cmd_reset is high), one line bit per enabled cycle.
- R3: In framed mode (raw_mode=0), cmd_start makes the line send the flag 0x7E, then the FIFO bytes; every byte and flag goes out LSB first, so the flag appears as 0,1,1,1,1,1,1,0.
- R4: In framed mode a 0 is inserted after every five consecutive 1s within payload and check-sequence bits; flag bits are never stuffed.
- R5: When the FIFO is empty at a byte boundary and cmd_end has been given, the frame closes with the complemented CRC-16 (polynomial x^16+x^12+x^5+1, preset 0xFFFF, computed LSB first over the unstuffed payload, shift-right form 0x8408) sent LSB first, then the flag 0x7E, then all-ones idle fill.
- R6: A cmd_start given while a frame is in progress is a continue: bytes written before the FIFO drains extend the same frame with no extra flag.
- R7: In framed mode, an empty FIFO at a byte boundary with no pending end aborts the frame with eight 1s (unstuffed), sets underrun, which stays set until cmd_reset, and returns the line to idle.
- R8: In raw mode (raw_mode=1), cmd_start sends the FIFO bytes LSB first with no flag, no check sequence and no inserted zeros; while the FIFO is empty the line carries 1s and underrun stays 0.
- R9: In raw mode, cmd_end stops transmission at the next byte boundary; bytes written afterwards stay in the FIFO and are not sent until a new cmd_start.
- R10: cmd_reset at any point aborts transmission, empties the FIFO and clears underrun; on the next clock edge tx_bit is 1 and fifo_ready is 1, and the line then stays at 1 until the next start.
- R11: fifo_ready is 1 exactly when the FIFO is empty; a write to a full FIFO (FIFO_DEPTH bytes held) is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-clock enable; one line bit per cycle where it is high |
| raw_mode | input | 1 | 0: framed HDLC mode, 1: raw pass-through mode |
| wr_en | input | 1 | Write strobe into the transmit FIFO |
| wr_data | input | 8 | Byte written into the transmit FIFO |
| cmd_start | input | 1 | Start or continue command pulse |
| cmd_end | input | 1 | End command pulse |
| cmd_reset | input | 1 | Transmitter reset command pulse |
| tx_bit | output | 1 | Serial line bit |
| fifo_ready | output | 1 | High when the transmit FIFO is empty |
| underrun | output | 1 | Sticky framed-mode underrun status |

## Verification
The bench builds the block with FIFO_DEPTH set to 4, so a full FIFO and a dropped fifth write are reached with only a handful of bytes, and a mid-frame continue needs a genuine refill after the FIFO has drained while the last byte is still on the line. The bit enable is divided by two and by three from the core clock, which leaves idle cycles in which the line must hold. Payloads with long runs of ones and embedded flag patterns drive the stuffing logic through both the payload and the check sequence.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FCS_W       = 16;
  localparam int unsigned STUFF_RUN   = 5;
  localparam logic [7:0]  HDLC_FLAG   = 8'h7E;
  localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_SR = 16'h8408;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DATA,
    PH_CLOSE,
    PH_RAW
  } phase_e;

  typedef enum logic [1:0] {
    SEG_PLAIN,
    SEG_DATA,
    SEG_FCS
  } seg_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             wr_ok, rd_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_data = mem_q[rp_q];
  assign wr_ok   = wr_en && !full && !flush;
  assign rd_ok   = rd_en && !empty && !flush;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (wr_ok) wp_n = (wp_q == LAST) ? '0 : wp_q + AW'(1);
      if (rd_ok) rp_n = (rp_q == LAST) ? '0 : rp_q + AW'(1);
      cnt_n = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= wr_data;
  end

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> (full && $stable(wp_q)));  // R11

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);  // R10
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic             din,
  output logic [FCS_W-1:0] crc
);
  logic [FCS_W-1:0] crc_q, crc_n;

  assign crc = crc_q;

  always_comb begin
    crc_n = crc_q;
    if (init) begin
      crc_n = FCS_PRESET;
    end else if (upd) begin
      crc_n = crc_q >> 1;
      if (crc_q[0] ^ din) crc_n = crc_n ^ FCS_POLY_SR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= FCS_PRESET;
    else        crc_q <= crc_n;
  end
endmodule

// File: rtl/hdlc_tx_serdes.sv
module hdlc_tx_serdes
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              raw_mode,
  input  logic              cmd_start,
  input  logic              cmd_end,
  input  logic              cmd_reset,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic [FCS_W-1:0]  fcs_val,
  output logic              fcs_init,
  output logic              fcs_upd,
  output logic              fcs_bit,
  output logic              tx_bit,
  output logic              underrun
);
  localparam logic [4:0] NB_BYTE = 5'd8;
  localparam logic [4:0] NB_FCS  = 5'(FCS_W);
  localparam logic [2:0] RUN_MAX = 3'(STUFF_RUN);
  localparam logic [15:0] FILL   = 16'hFFFF;

  phase_e      ph_q, ph_n;
  seg_e        seg_q, seg_n, seg_w;
  logic [15:0] sh_q, sh_n, sh_w;
  logic [4:0]  nl_q, nl_n, nl_w;
  logic [2:0]  ones_q, ones_n;
  logic        tx_q, tx_n;
  logic        go_q, go_n;
  logic        end_q, end_n;
  logic        und_q, und_n;
  logic        clr;

  assign tx_bit   = tx_q;
  assign underrun = und_q;

  always_comb begin
    ph_n     = ph_q;
    seg_n    = seg_q;
    sh_n     = sh_q;
    nl_n     = nl_q;
    ones_n   = ones_q;
    tx_n     = tx_q;
    go_n     = go_q;
    end_n    = end_q;
    und_n    = und_q;
    sh_w     = sh_q;
    nl_w     = nl_q;
    seg_w    = seg_q;
    clr      = 1'b0;
    fifo_pop = 1'b0;
    fcs_init = 1'b0;
    fcs_upd  = 1'b0;
    fcs_bit  = 1'b0;

    if (bit_en) begin
      if (ones_q == RUN_MAX) begin
        tx_n   = 1'b0;
        ones_n = '0;
      end else begin
        if (nl_q == '0) begin
          sh_w  = FILL;
          nl_w  = 5'd1;
          seg_w = SEG_PLAIN;
          case (ph_q)
            PH_IDLE: begin
              if (go_q) begin
                if (raw_mode) begin
                  ph_n = PH_RAW;
                end else begin
                  sh_w     = {8'hFF, HDLC_FLAG};
                  nl_w     = NB_BYTE;
                  fcs_init = 1'b1;
                  ph_n     = PH_DATA;
                end
              end
            end
            PH_RAW: begin
              if (end_q) begin
                clr  = 1'b1;
                ph_n = PH_IDLE;
              end else if (!fifo_empty) begin
                fifo_pop = 1'b1;
                sh_w     = {8'hFF, fifo_data};
                nl_w     = NB_BYTE;
              end
            end
            PH_DATA: begin
              if (!fifo_empty) begin
                fifo_pop = 1'b1;
                sh_w     = {8'hFF, fifo_data};
                nl_w     = NB_BYTE;
                seg_w    = SEG_DATA;
              end else if (end_q) begin
                sh_w  = ~fcs_val;
                nl_w  = NB_FCS;
                seg_w = SEG_FCS;
                ph_n  = PH_CLOSE;
              end else begin
                nl_w  = NB_BYTE;
                und_n = 1'b1;
                clr   = 1'b1;
                ph_n  = PH_IDLE;
              end
            end
            PH_CLOSE: begin
              sh_w = {8'hFF, HDLC_FLAG};
              nl_w = NB_BYTE;
              clr  = 1'b1;
              ph_n = PH_IDLE;
            end
            default: ;
          endcase
        end
        tx_n  = sh_w[0];
        sh_n  = {1'b1, sh_w[15:1]};
        nl_n  = nl_w - 5'd1;
        seg_n = seg_w;
        if (seg_w != SEG_PLAIN) ones_n = sh_w[0] ? ones_q + 3'd1 : 3'd0;
        else                    ones_n = '0;
        if (seg_w == SEG_DATA) begin
          fcs_upd = 1'b1;
          fcs_bit = sh_w[0];
        end
      end
    end

    if (clr) begin
      go_n  = 1'b0;
      end_n = 1'b0;
    end
    if (cmd_start) go_n  = 1'b1;
    if (cmd_end)   end_n = 1'b1;

    if (cmd_reset) begin
      ph_n     = PH_IDLE;
      seg_n    = SEG_PLAIN;
      sh_n     = FILL;
      nl_n     = '0;
      ones_n   = '0;
      tx_n     = 1'b1;
      go_n     = 1'b0;
      end_n    = 1'b0;
      und_n    = 1'b0;
      fifo_pop = 1'b0;
      fcs_init = 1'b0;
      fcs_upd  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      seg_q  <= SEG_PLAIN;
      sh_q   <= FILL;
      nl_q   <= '0;
      ones_q <= '0;
      tx_q   <= 1'b1;
      go_q   <= 1'b0;
      end_q  <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      seg_q  <= seg_n;
      sh_q   <= sh_n;
      nl_q   <= nl_n;
      ones_q <= ones_n;
      tx_q   <= tx_n;
      go_q   <= go_n;
      end_q  <= end_n;
      und_q  <= und_n;
    end
  end

  AST_STUFF_ZERO_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ones_q == RUN_MAX && !cmd_reset) |=> !tx_bit);  // R4

  AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !cmd_reset) |=> $stable(tx_bit));  // R2

  AST_RESET_IDLES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (tx_bit && !underrun && ph_q == PH_IDLE));  // R10

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !cmd_reset) |=> underrun);  // R7

  AST_RAW_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RAW && !underrun) |=> !underrun);  // R8
endmodule

// File: rtl/hdlc_dual_tx.sv
module hdlc_dual_tx
  import hdlc_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       raw_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_start,
  input  logic       cmd_end,
  input  logic       cmd_reset,
  output logic       tx_bit,
  output logic       fifo_ready,
  output logic       underrun
);
  logic [1:0]        rsync_q;
  logic              core_rst_n;
  logic              f_empty, f_full, f_pop;
  logic [BYTE_W-1:0] f_data;
  logic [FCS_W-1:0]  fcs_val;
  logic              fcs_init, fcs_upd, fcs_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  assign fifo_ready = f_empty;

  hdlc_tx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (BYTE_W)
  ) fifo_i (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .flush   (cmd_reset),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (f_pop),
    .rd_data (f_data),
    .empty   (f_empty),
    .full    (f_full)
  );

  hdlc_tx_fcs fcs_i (
    .clk   (clk),
    .rst_n (core_rst_n),
    .init  (fcs_init),
    .upd   (fcs_upd),
    .din   (fcs_bit),
    .crc   (fcs_val)
  );

  hdlc_tx_serdes ser_i (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .bit_en     (bit_en),
    .raw_mode   (raw_mode),
    .cmd_start  (cmd_start),
    .cmd_end    (cmd_end),
    .cmd_reset  (cmd_reset),
    .fifo_empty (f_empty),
    .fifo_data  (f_data),
    .fifo_pop   (f_pop),
    .fcs_val    (fcs_val),
    .fcs_init   (fcs_init),
    .fcs_upd    (fcs_upd),
    .fcs_bit    (fcs_bit),
    .tx_bit     (tx_bit),
    .underrun   (underrun)
  );

  AST_FULL_MEANS_BUSY: assert property (@(posedge clk) disable iff (!core_rst_n)
    f_full |-> !fifo_ready);  // R11
endmodule

// File: tb/hdlc_dual_tx_tb_top.sv
module hdlc_dual_tx_tb_top;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       raw_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_start = 1'b0;
  logic       cmd_end = 1'b0;
  logic       cmd_reset = 1'b0;
  logic       tx_bit, fifo_ready, underrun;

  int errors = 0;
  int checks = 0;
  int div = 2;
  int en_cnt = 0;
  logic en_seen = 1'b0;
  logic rs_seen = 1'b0;
  logic prev_tx = 1'b1;
  logic cap_on = 1'b0;
  int viol = 0;
  bit cap[$];
  bit exp_q[$];
  logic [7:0] pay[$];
  int run = 0;
  logic [15:0] crc = 16'hFFFF;

  always #4 clk = ~clk;

  hdlc_dual_tx #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .raw_mode(raw_mode),
    .wr_en(wr_en), .wr_data(wr_data), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .cmd_reset(cmd_reset), .tx_bit(tx_bit), .fifo_ready(fifo_ready), .underrun(underrun)
  );

  always @(negedge clk) begin
    en_cnt = (en_cnt + 1) % div;
    bit_en <= (en_cnt == 0);
  end

  always @(posedge clk) begin
    en_seen <= bit_en;
    rs_seen <= cmd_reset;
  end

  always @(negedge clk) begin
    if (rst_n && cap_on && en_seen) cap.push_back(tx_bit);
    if (rst_n && !en_seen && !rs_seen && tx_bit !== prev_tx) viol++;
    prev_tx = tx_bit;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void e_plain(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    run = 0;
  endfunction

  function automatic void e_stuffed(input bit b);
    exp_q.push_back(b);
    if (b) begin
      run++;
      if (run == 5) begin
        exp_q.push_back(1'b0);
        run = 0;
      end
    end else run = 0;
  endfunction

  function automatic void e_data(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb  = crc[0] ^ b[i];
      crc = crc >> 1;
      if (fb) crc = crc ^ 16'h8408;
      e_stuffed(b[i]);
    end
  endfunction

  function automatic void e_open();
    exp_q.delete();
    run = 0;
    crc = 16'hFFFF;
    e_plain(8'h7E);
  endfunction

  function automatic void e_close();
    logic [15:0] f;
    f = ~crc;
    for (int i = 0; i < 16; i++) e_stuffed(f[i]);
    e_plain(8'h7E);
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n * div) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_cmd(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1'b1;
    else if (which == 1) cmd_end = 1'b1;
    else cmd_reset = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    cmd_end = 1'b0;
    cmd_reset = 1'b0;
  endtask

  task automatic compare_stream(input string req, input string what, input int tail_ones);
    int start = -1;
    int bad = -1;
    int zeros = 0;
    for (int i = 0; i < cap.size(); i++) begin
      if (cap[i] == 1'b0) begin
        start = i;
        break;
      end
    end
    if (start < 0 || start + exp_q.size() + tail_ones > cap.size()) begin
      chk(1'b0, req, {what, " captured length"}, cap.size(), exp_q.size() + tail_ones);
      return;
    end
    for (int i = 0; i < exp_q.size(); i++) begin
      if (bad < 0 && cap[start + i] != exp_q[i]) bad = i;
    end
    chk(bad < 0, req, {what, " bit stream (value at first mismatch)"},
        (bad < 0) ? 0 : int'(cap[start + bad]), (bad < 0) ? 0 : int'(exp_q[bad]));
    for (int i = 0; i < tail_ones; i++) if (cap[start + exp_q.size() + i] == 1'b0) zeros++;
    chk(zeros == 0, req, {what, " ones after frame (zero count)"}, zeros, 0);
  endtask

  task automatic check_all_ones(input string req, input string what, input int min_bits);
    int zeros = 0;
    foreach (cap[i]) if (cap[i] == 1'b0) zeros++;
    chk(zeros == 0 && cap.size() >= min_bits, req, {what, " zero count"}, zeros, 0);
  endtask

  task automatic run_framed(input string req, input string what, input int keep);
    e_open();
    for (int i = 0; i < keep; i++) e_data(pay[i]);
    e_close();
    for (int i = 0; i < pay.size(); i++) write_byte(pay[i]);
    chk(fifo_ready == 1'b0, "R11", {what, " ready low while loaded"}, int'(fifo_ready), 0);
    cap.delete();
    cap_on = 1'b1;
    pulse_cmd(0);
    pulse_cmd(1);
    wait_ticks(exp_q.size() + 40);
    compare_stream(req, what, 16);
    chk(fifo_ready == 1'b1 && underrun == 1'b0, req, {what, " ready after frame"}, int'(fifo_ready), 1);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_bit == 1'b1, "R1", "line idle after reset", int'(tx_bit), 1);
    chk(fifo_ready == 1'b1, "R1", "ready after reset", int'(fifo_ready), 1);
    chk(underrun == 1'b0, "R1", "underrun after reset", int'(underrun), 0);
  endtask

  task automatic t_frame_basic();
    div = 2;
    pay = '{8'h12, 8'hFF, 8'h3E};
    run_framed("R3/R4/R5", "framed basic", 3);
  endtask

  task automatic t_stuff_heavy();
    div = 3;
    pay = '{8'hFF, 8'hFF, 8'h7E, 8'hF8};
    run_framed("R4/R5/R2", "stuffing heavy", 4);
    div = 2;
  endtask

  task automatic t_continue();
    int guard = 0;
    pay = '{8'h01, 8'h80, 8'hC3, 8'h5A, 8'hE7, 8'h00, 8'hFF, 8'h81};
    e_open();
    foreach (pay[i]) e_data(pay[i]);
    e_close();
    for (int i = 0; i < 4; i++) write_byte(pay[i]);
    cap.delete();
    cap_on = 1'b1;
    pulse_cmd(0);
    @(negedge clk);
    while (!fifo_ready && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    for (int i = 4; i < 8; i++) write_byte(pay[i]);
    pulse_cmd(0);
    pulse_cmd(1);
    wait_ticks(exp_q.size() + 40);
    compare_stream("R6", "continued frame", 16);
    chk(underrun == 1'b0, "R6", "no underrun on continue", int'(underrun), 0);
  endtask

  task automatic t_full_drop();
    pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    run_framed("R11", "fifth write dropped", 4);
  endtask

  task automatic t_underrun();
    pay = '{8'hA5, 8'h0F};
    e_open();
    foreach (pay[i]) e_data(pay[i]);
    e_plain(8'hFF);
    foreach (pay[i]) write_byte(pay[i]);
    cap.delete();
    cap_on = 1'b1;
    pulse_cmd(0);
    wait_ticks(exp_q.size() + 40);
    compare_stream("R7", "underrun abort", 8);
    chk(underrun == 1'b1, "R7", "underrun raised", int'(underrun), 1);
    wait_ticks(10);
    chk(underrun == 1'b1, "R7", "underrun sticky", int'(underrun), 1);
    pulse_cmd(2);
    chk(underrun == 1'b0, "R10", "underrun cleared by reset", int'(underrun), 0);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) write_byte(8'h00);
    pulse_cmd(0);
    wait_ticks(14);
    pulse_cmd(2);
    chk(fifo_ready == 1'b1, "R10", "ready right after reset", int'(fifo_ready), 1);
    chk(tx_bit == 1'b1, "R10", "line high right after reset", int'(tx_bit), 1);
    cap.delete();
    cap_on = 1'b1;
    wait_ticks(40);
    check_all_ones("R10", "idle after mid-frame reset", 30);
    pay = '{8'h5A};
    run_framed("R10", "frame after reset", 1);
  endtask

  task automatic t_raw();
    raw_mode = 1'b1;
    pay = '{8'h3C, 8'hFF, 8'hF0};
    exp_q.delete();
    foreach (pay[i]) e_plain(pay[i]);
    foreach (pay[i]) write_byte(pay[i]);
    cap.delete();
    cap_on = 1'b1;
    pulse_cmd(0);
    wait_ticks(60);
    compare_stream("R8", "raw pass-through", 8);
    chk(underrun == 1'b0, "R8", "no underrun in raw", int'(underrun), 0);
    pulse_cmd(1);
    wait_ticks(4);
    write_byte(8'h00);
    cap.delete();
    wait_ticks(30);
    check_all_ones("R9", "line after raw end", 20);
    chk(fifo_ready == 1'b0, "R9", "byte held after raw end", int'(fifo_ready), 0);
    pulse_cmd(2);
    raw_mode = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_frame_basic();
    t_stuff_heavy();
    t_continue();
    t_full_drop();
    t_underrun();
    t_reset_mid();
    t_raw();
    chk(viol == 0, "R2", "line changes without enable", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule